// File: doc/BRIEF.md
# Low-Transition Scan Pattern Generator

This block feeds pseudo-random serial stimulus to a scan chain in a built-in self-test arrangement where one complete chain load is shifted in for each applied test. The source is a pseudo-random sequence from a maximal-length linear feedback shift register. That raw sequence is not shifted out directly. The lowest K register stages feed an AND gate, and the gate output drives the toggle input of a flip-flop. The flip-flop output is the scan-in bit. Because the bit only changes when all K stages are 1, consecutive scan bits differ with a probability of about 1/2^K. This lowers switching activity in the chain during shifting and keeps the stimulus pseudo-random.

A shift counter sized to the scan-chain length gives a one-cycle marker after every complete chain load. The surrounding test controller uses this marker to issue the capture cycle. A seed can be loaded through a parallel port, either during synchronous reset or while the block is running. A zero seed would lock the register, so it is replaced by a fixed non-zero constant.

Top module: `lt_scan_tpg`

## Requirements
- R1: While `rst` is high at a rising edge, the following edge leaves `scan_in` at 0 and `pattern_done` at 0, and loads the register from `seed` as R6 describes.
- R2: On each enabled shift, the 16-bit register moves one place toward the MSB. The new bit 0 is the XOR of bits 15, 13, 12 and 10, which is the polynomial x^16+x^14+x^13+x^11+1.
- R3: On an enabled shift, `scan_in` inverts when bits [K-1:0] of the register are all 1 just before the edge (K=2 by default). Otherwise `scan_in` keeps its value.
- R4: When `en` is low, neither the register, `scan_in` nor the shift count changes, and `pattern_done` is 0 in the next cycle.
- R5: When `seed_load` is high, the next edge loads the register from `seed`, and `seed_load` takes priority over `en`. No shift happens on that edge, and both `scan_in` and the shift count keep their values.
- R6: A seed value of zero, whether taken at reset or at a load, is replaced by 16'hACE1. The register is never zero outside reset.
- R7: `pattern_done` is high for exactly the one cycle that follows every CHAIN_LEN-th enabled shift counted since reset (CHAIN_LEN=64 by default). It is low at all other times.
- R8: Over 4000 consecutive enabled shifts with K=2, the fraction of shifts on which `scan_in` changes lies between 0.20 and 0.30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads `seed` |
| en | input | 1 | Advance the generator by one shift |
| seed_load | input | 1 | Load `seed` into the register on the next edge |
| seed | input | 16 | Parallel seed value |
| scan_in | output | 1 | Serial bit driven into the scan chain |
| pattern_done | output | 1 | One-cycle marker after a complete chain load |

## Verification
The bench keeps a model of the register, the AND gate, the toggle stage and the shift count, and compares both outputs to it on every cycle. A wrong tap or a wrong shift direction makes the serial stream drift from the model within a few dozen bits. An inverted or widened AND term shows up both in the bit-by-bit comparison and in the measured toggle rate, which moves far from one quarter. Loads issued while the block is idle, a zero seed at a load and at reset, and loads placed between pulses are there to catch three faults: a load that also shifts or clears the toggle bit, a counter that keeps counting while idle or across loads, and a register that locks at zero. The toggle rate over a long run catches a generator that follows the raw register bit instead.

// File: rtl/lt_tpg_pkg.sv
package lt_tpg_pkg;
    typedef enum logic [1:0] {
        LF_HOLD  = 2'd0,
        LF_SHIFT = 2'd1,
        LF_LOAD  = 2'd2
    } lf_act_e;
endpackage

// File: rtl/lt_lfsr.sv
module lt_lfsr
    import lt_tpg_pkg::*;
#(
    parameter int          W       = 16,
    parameter logic [W-1:0] TAPS    = 16'hB400,
    parameter logic [W-1:0] NZ_SEED = 16'hACE1
) (
    input  logic         clk,
    input  lf_act_e      act,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    typedef struct packed {
        logic [W-1:0] sr;
    } lf_st_t;

    lf_st_t st_d, st_q;
    logic   fb;

    always_comb begin
        st_d = st_q;
        fb   = ^(st_q.sr & TAPS);
        unique case (act)
            LF_LOAD:  st_d.sr = (seed == '0) ? NZ_SEED : seed;
            LF_SHIFT: st_d.sr = {st_q.sr[W-2:0], fb};
            default:  st_d.sr = st_q.sr;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign state = st_q.sr;
endmodule

// File: rtl/lt_toggle.sv
module lt_toggle #(
    parameter int K = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [K-1:0] sel,
    output logic         q
);
    typedef struct packed {
        logic t;
    } tg_st_t;

    tg_st_t st_d, st_q;
    logic   t_in;

    always_comb begin
        st_d = st_q;
        t_in = &sel;
        if (rst)
            st_d.t = 1'b0;
        else if (step && t_in)
            st_d.t = ~st_q.t;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.t;
endmodule

// File: rtl/lt_pat_cnt.sv
module lt_pat_cnt #(
    parameter int CHAIN_LEN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic done
);
    localparam int CNT_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } pc_st_t;

    pc_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (rst) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign done = st_q.done;
endmodule

// File: rtl/lt_scan_tpg.sv
module lt_scan_tpg
    import lt_tpg_pkg::*;
#(
    parameter int           W         = 16,
    parameter logic [W-1:0] TAPS      = 16'hB400,
    parameter logic [W-1:0] NZ_SEED   = 16'hACE1,
    parameter int           K         = 2,
    parameter int           CHAIN_LEN = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         seed_load,
    input  logic [W-1:0] seed,
    output logic         scan_in,
    output logic         pattern_done
);
    lf_act_e      act;
    logic         step;
    logic [W-1:0] lfsr_q;

    always_comb begin
        step = en && !seed_load && !rst;
        if (rst || seed_load)
            act = LF_LOAD;
        else if (en)
            act = LF_SHIFT;
        else
            act = LF_HOLD;
    end

    lt_lfsr #(.W(W), .TAPS(TAPS), .NZ_SEED(NZ_SEED)) u_lfsr (
        .clk  (clk),
        .act  (act),
        .seed (seed),
        .state(lfsr_q)
    );

    lt_toggle #(.K(K)) u_tog (
        .clk (clk),
        .rst (rst),
        .step(step),
        .sel (lfsr_q[K-1:0]),
        .q   (scan_in)
    );

    lt_pat_cnt #(.CHAIN_LEN(CHAIN_LEN)) u_cnt (
        .clk (clk),
        .rst (rst),
        .step(step),
        .done(pattern_done)
    );
endmodule

// File: rtl/lt_scan_tpg_chk.sv
module lt_scan_tpg_chk #(
    parameter int           W       = 16,
    parameter logic [W-1:0] NZ_SEED = 16'hACE1,
    parameter int           K       = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         seed_load,
    input logic [W-1:0] seed,
    input logic [W-1:0] lfsr_q,
    input logic         scan_in,
    input logic         pattern_done
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!scan_in && !pattern_done));

    p_shift_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load) |=> (lfsr_q[W-1:1] == $past(lfsr_q[W-2:0])));

    p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load && (&lfsr_q[K-1:0])) |=> (scan_in != $past(scan_in)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load && !(&lfsr_q[K-1:0])) |=> $stable(scan_in));

    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!en && !seed_load) |=> ($stable(scan_in) && $stable(lfsr_q) && !pattern_done));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (lfsr_q == (($past(seed) == '0) ? NZ_SEED : $past(seed))) && $stable(scan_in));

    p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        pattern_done |=> !pattern_done);

    p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
        pattern_done |-> $past(en && !seed_load));
endmodule

bind lt_scan_tpg lt_scan_tpg_chk #(.W(W), .NZ_SEED(NZ_SEED), .K(K)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .seed_load   (seed_load),
    .seed        (seed),
    .lfsr_q      (lfsr_q),
    .scan_in     (scan_in),
    .pattern_done(pattern_done)
);

// File: tb/lt_scan_tpg_tb.sv
module lt_scan_tpg_tb;
    localparam int          CH   = 64;
    localparam logic [15:0] TAPS = 16'hB400;
    localparam logic [15:0] NZ   = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed = 16'h1234;
    logic        scan_in;
    logic        pattern_done;

    always #4 clk = ~clk;

    lt_scan_tpg u_dut (
        .clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
        .seed(seed), .scan_in(scan_in), .pattern_done(pattern_done)
    );

    typedef struct {
        logic  si;
        logic  done;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    int n_chk = 0;
    int n_bad = 0;
    int tog_cnt = 0;
    int tog_n = 0;
    logic prev_si = 1'b0;

    logic [15:0] m_lf = '0;
    logic        m_t = 1'b0;
    int          m_cnt = 0;
    logic        m_done = 1'b0;

    task automatic step(input logic r, input logic e, input logic l,
                        input logic [15:0] s, input string tag);
        exp_t it;
        @(negedge clk);
        rst = r; en = e; seed_load = l; seed = s;
        if (r) begin
            m_lf = (s == 16'h0) ? NZ : s;
            m_t = 1'b0; m_cnt = 0; m_done = 1'b0;
        end else if (l) begin
            m_lf = (s == 16'h0) ? NZ : s;
            m_done = 1'b0;
        end else if (e) begin
            if (m_lf[1] && m_lf[0]) m_t = ~m_t;
            m_lf = {m_lf[14:0], ^(m_lf & TAPS)};
            if (m_cnt == CH - 1) begin m_cnt = 0; m_done = 1'b1; end
            else begin m_cnt++; m_done = 1'b0; end
        end else begin
            m_done = 1'b0;
        end
        it.si = m_t; it.done = m_done; it.tag = tag;
        exp_q.push_back(it);
    endtask

    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (scan_in !== it.si) begin
                n_bad++;
                $display("FAIL %s scan_in: actual %b expected %b", it.tag, scan_in, it.si);
            end
            n_chk++;
            if (pattern_done !== it.done) begin
                n_bad++;
                $display("FAIL R7 (%s) pattern_done: actual %b expected %b",
                         it.tag, pattern_done, it.done);
            end
            if (it.tag == "R8") begin
                tog_n++;
                if (scan_in != prev_si) tog_cnt++;
            end
            prev_si = scan_in;
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        real rate;
        // R1: reset with a non-zero seed
        step(1, 0, 0, 16'h1234, "R1");
        step(1, 1, 0, 16'h1234, "R1");
        // R2/R3/R7: free run across three chain loads
        for (int i = 0; i < 200; i++) step(0, 1, 0, 16'h0, "R3");
        // R4: idle gaps between shifts
        for (int i = 0; i < 40; i++) step(0, (i % 3) == 0, 0, 16'hFFFF, "R4");
        // R5: load during idle and during enable, mid pattern
        step(0, 0, 1, 16'hBEEF, "R5");
        for (int i = 0; i < 30; i++) step(0, 1, 0, 16'h0, "R2");
        step(0, 1, 1, 16'h0F0F, "R5");
        for (int i = 0; i < 70; i++) step(0, 1, 0, 16'h0, "R7");
        // R6: zero seed at a load and at reset
        step(0, 1, 1, 16'h0000, "R6");
        for (int i = 0; i < 50; i++) step(0, 1, 0, 16'h0, "R6");
        step(1, 0, 0, 16'h0000, "R1");
        for (int i = 0; i < 70; i++) step(0, 1, 0, 16'h0, "R6");
        // R8: long run for toggle rate
        for (int i = 0; i < 4000; i++) step(0, 1, 0, 16'h0, "R8");
        step(0, 0, 0, 16'h0, "R4");
        repeat (3) @(negedge clk);
        rate = real'(tog_cnt) / real'(tog_n);
        n_chk++;
        if (rate < 0.20 || rate > 0.30) begin
            n_bad++;
            $display("FAIL R8 toggle rate: actual %f expected 0.20..0.30", rate);
        end
        finish_run();
    end
endmodule